// File: doc/BRIEF.md
# Remote DMA Ready Status Tracker

This block produces the three readiness bits a host polls before touching a remote DMA data port. It holds a 16-bit remaining byte count. Software loads the count through two separate 8-bit writes, one for the low byte and one for the high byte. Every access to the data port then counts it down.

From that count, and from a few state inputs, the block drives an 8-bit status value:

- **Bit 4, general readiness.** It drops while the device is resetting, saving power, loading configuration or switching loopback mode.
- **Bit 5, read-data readiness.** It falls when a remote-read command is issued. It rises again once the read FIFO reports valid data.
- **Bit 6, transfer completion.** It falls on any count write. It rises when an access drives the count to zero.

The read FIFO, the buffer memory and the rest of the DMA engine lie outside the block. It only observes their strobes. The remaining count is also visible, so software can read back how much of a transfer is left.

Top module: `rdma_ready_tracker`

## Requirements
- R1: Status bit 4 is 0 in the cycle after any of `sw_reset_i`, `power_save_i`, `cfg_load_i` or `lpbk_switch_i` is 1. It is 1 in the cycle after all four are 0.
- R2: A 1 on `rd_cmd_i` makes status bit 5 read 0 on the next cycle. This holds even if `fifo_valid_i` is 1 in the same cycle.
- R3: A 1 on `fifo_valid_i` without `rd_cmd_i` makes status bit 5 read 1 on the next cycle. Bit 5 then holds at 1 through any number of data-port accesses until the next read command.
- R4: `cnt_lo_wr_i` loads `cnt_wdata_i` into bits 7:0 of the count. `cnt_hi_wr_i` loads it into bits 15:8. Each write leaves the other byte unchanged, and the result is shown on `remain_cnt_o` on the next cycle.
- R5: Any count write makes status bit 6 read 0 on the next cycle. A count write and a data-port access in the same cycle: the write takes effect and the access is dropped.
- R6: A data-port access with no count write lowers the count by 1 when `wide_mode_i` is 0 and by 2 when it is 1. The count saturates at 0 and never wraps.
- R7: After an access, status bit 6 is 1 exactly when the resulting count is 0. Loading a count of 0 leaves bit 6 at 0 until the next access.
- R8: After reset, status and count are all 0. Status bits 7 and 3:0 always read 0.
- R9: In a cycle with neither a count write nor an access, the count and status bit 6 keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sw_reset_i | input | 1 | Device in reset state |
| power_save_i | input | 1 | Device in power saving |
| cfg_load_i | input | 1 | Configuration load in progress |
| lpbk_switch_i | input | 1 | Loopback mode switching |
| cnt_lo_wr_i | input | 1 | Write low byte of the byte count |
| cnt_hi_wr_i | input | 1 | Write high byte of the byte count |
| cnt_wdata_i | input | 8 | Byte-count write data |
| rd_cmd_i | input | 1 | Remote-read command issued |
| fifo_valid_i | input | 1 | Read FIFO presents valid data |
| dp_access_i | input | 1 | Data-port access |
| wide_mode_i | input | 1 | Data port is 16 bits wide (step of 2) |
| status_o | output | 8 | Device status: bit 4 ready, bit 5 read data ready, bit 6 DMA complete |
| remain_cnt_o | output | 16 | Remaining byte count |

## Verification
The assertions check every cycle for the following:

- each readiness input forces its status bit on the next cycle;
- a count write clears the completion bit;
- an access never raises the count;
- completion after an access follows whether the count is zero;
- reserved bits stay zero;
- count and completion hold in idle cycles.

The exact arithmetic needs the bench's scenarios. These cover:

- byte-lane loads that leave the other byte intact;
- narrow and wide step sizes;
- saturation from an odd count in wide mode;
- a zero load that keeps completion low until an access;
- a write that wins against a simultaneous access.

// File: rtl/rdma_ready_pkg.sv
package rdma_ready_pkg;
  localparam int unsigned STATUS_W  = 8;
  localparam int unsigned DEV_BIT   = 4;
  localparam int unsigned RDATA_BIT = 5;
  localparam int unsigned DONE_BIT  = 6;
  localparam int unsigned N_BUSY    = 4;

  typedef struct packed {
    logic dma_done;
    logic rd_rdy;
    logic dev_rdy;
  } rdy_flags_t;
endpackage

// File: rtl/rdma_byte_counter.sv
module rdma_byte_counter #(
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned N_LANE = 2,
  localparam int unsigned CNT_W = BYTE_W * N_LANE
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_LANE-1:0] lane_wr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic              access_i,
  input  logic              wide_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              done_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d, step;
  logic             done_q, done_d;

  assign step = wide_i ? CNT_W'(2) : CNT_W'(1);

  always_comb begin
    cnt_d  = cnt_q;
    done_d = done_q;
    if (|lane_wr_i) begin
      // load wins over a same-cycle access
      for (int i = 0; i < int'(N_LANE); i++) begin
        if (lane_wr_i[i]) cnt_d[i*BYTE_W +: BYTE_W] = wdata_i;
      end
      done_d = 1'b0;
    end else if (access_i) begin
      cnt_d  = (cnt_q > step) ? cnt_q - step : '0;
      done_d = (cnt_q <= step);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      done_q <= done_d;
    end
  end

  assign cnt_o  = cnt_q;
  assign done_o = done_q;
endmodule

// File: rtl/rdma_ready_flags.sv
module rdma_ready_flags #(
  parameter int unsigned N_BUSY = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_BUSY-1:0] busy_i,
  input  logic              rd_cmd_i,
  input  logic              fifo_valid_i,
  output logic              dev_rdy_o,
  output logic              rd_rdy_o
);
  logic dev_q, rd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dev_q <= 1'b0;
      rd_q  <= 1'b0;
    end else begin
      dev_q <= ~|busy_i;
      if (rd_cmd_i)          rd_q <= 1'b0;
      else if (fifo_valid_i) rd_q <= 1'b1;
    end
  end

  assign dev_rdy_o = dev_q;
  assign rd_rdy_o  = rd_q;
endmodule

// File: rtl/rdma_ready_tracker.sv
module rdma_ready_tracker
  import rdma_ready_pkg::*;
#(
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned CNT_W = 2 * BYTE_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                sw_reset_i,
  input  logic                power_save_i,
  input  logic                cfg_load_i,
  input  logic                lpbk_switch_i,
  input  logic                cnt_lo_wr_i,
  input  logic                cnt_hi_wr_i,
  input  logic [BYTE_W-1:0]   cnt_wdata_i,
  input  logic                rd_cmd_i,
  input  logic                fifo_valid_i,
  input  logic                dp_access_i,
  input  logic                wide_mode_i,
  output logic [STATUS_W-1:0] status_o,
  output logic [CNT_W-1:0]    remain_cnt_o
);
  rdy_flags_t flags;

  rdma_ready_flags #(.N_BUSY(N_BUSY)) i_flags (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .busy_i       ({lpbk_switch_i, cfg_load_i, power_save_i, sw_reset_i}),
    .rd_cmd_i     (rd_cmd_i),
    .fifo_valid_i (fifo_valid_i),
    .dev_rdy_o    (flags.dev_rdy),
    .rd_rdy_o     (flags.rd_rdy)
  );

  rdma_byte_counter #(.BYTE_W(BYTE_W), .N_LANE(2)) i_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .lane_wr_i ({cnt_hi_wr_i, cnt_lo_wr_i}),
    .wdata_i   (cnt_wdata_i),
    .access_i  (dp_access_i),
    .wide_i    (wide_mode_i),
    .cnt_o     (remain_cnt_o),
    .done_o    (flags.dma_done)
  );

  always_comb begin
    status_o            = '0;
    status_o[DEV_BIT]   = flags.dev_rdy;
    status_o[RDATA_BIT] = flags.rd_rdy;
    status_o[DONE_BIT]  = flags.dma_done;
  end
endmodule

// File: rtl/rdma_ready_checker.sv
module rdma_ready_checker (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        sw_reset_i,
  input logic        power_save_i,
  input logic        cfg_load_i,
  input logic        lpbk_switch_i,
  input logic        cnt_lo_wr_i,
  input logic        cnt_hi_wr_i,
  input logic        rd_cmd_i,
  input logic        fifo_valid_i,
  input logic        dp_access_i,
  input logic [7:0]  status_o,
  input logic [15:0] remain_cnt_o
);
  logic busy, wr, acc_only;
  assign busy     = sw_reset_i | power_save_i | cfg_load_i | lpbk_switch_i;
  assign wr       = cnt_lo_wr_i | cnt_hi_wr_i;
  assign acc_only = dp_access_i & ~wr;

  p_busy_drops_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |=> !status_o[4]);
  p_idle_ready_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |=> status_o[4]);
  p_rd_cmd_clears_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_cmd_i |=> !status_o[5]);
  p_valid_sets_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fifo_valid_i && !rd_cmd_i) |=> status_o[5]);
  p_rd_rdy_holds_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o[5] && !rd_cmd_i) |=> status_o[5]);
  p_wr_clears_done_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr |=> !status_o[6]);
  p_no_wrap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_only |=> remain_cnt_o <= $past(remain_cnt_o));
  p_done_on_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_only |=> (status_o[6] == (remain_cnt_o == 16'd0)));
  p_reserved_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o & 8'h8F) == 8'h00);
  p_idle_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr && !dp_access_i) |=> ($stable(remain_cnt_o) && $stable(status_o[6])));
endmodule

bind rdma_ready_tracker rdma_ready_checker i_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .sw_reset_i    (sw_reset_i),
  .power_save_i  (power_save_i),
  .cfg_load_i    (cfg_load_i),
  .lpbk_switch_i (lpbk_switch_i),
  .cnt_lo_wr_i   (cnt_lo_wr_i),
  .cnt_hi_wr_i   (cnt_hi_wr_i),
  .rd_cmd_i      (rd_cmd_i),
  .fifo_valid_i  (fifo_valid_i),
  .dp_access_i   (dp_access_i),
  .status_o      (status_o),
  .remain_cnt_o  (remain_cnt_o)
);

// File: tb/test_rdma_ready_tracker.sv
module test_rdma_ready_tracker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sw_reset = 0, power_save = 0, cfg_load = 0, lpbk_switch = 0;
  logic        cnt_lo_wr = 0, cnt_hi_wr = 0;
  logic [7:0]  cnt_wdata = '0;
  logic        rd_cmd = 0, fifo_valid = 0, dp_access = 0, wide_mode = 0;
  logic [7:0]  status;
  logic [15:0] remain_cnt;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  typedef struct {
    logic [7:0]  st;
    logic [15:0] cnt;
    string       req;
  } exp_t;
  exp_t sb[$];

  // reference model state
  logic        m_dev = 0, m_rd = 0, m_done = 0;
  logic [15:0] m_cnt = '0;

  always #5 clk = ~clk;

  rdma_ready_tracker i_rdma_ready_tracker (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .sw_reset_i    (sw_reset),
    .power_save_i  (power_save),
    .cfg_load_i    (cfg_load),
    .lpbk_switch_i (lpbk_switch),
    .cnt_lo_wr_i   (cnt_lo_wr),
    .cnt_hi_wr_i   (cnt_hi_wr),
    .cnt_wdata_i   (cnt_wdata),
    .rd_cmd_i      (rd_cmd),
    .fifo_valid_i  (fifo_valid),
    .dp_access_i   (dp_access),
    .wide_mode_i   (wide_mode),
    .status_o      (status),
    .remain_cnt_o  (remain_cnt)
  );

  task automatic check(input string req, input logic [7:0] st, input logic [15:0] cnt);
    checks++;
    if (status !== st || remain_cnt !== cnt) begin
      errors++;
      $display("FAIL %s: status=%02h cnt=%04h expected status=%02h cnt=%04h",
               req, status, remain_cnt, st, cnt);
    end
  endtask

  // driver: one cycle of stimulus, model update, expected item pushed
  task automatic cyc(input string req, input logic [3:0] busy, input logic lo, input logic hi,
                     input logic [7:0] d, input logic rc, input logic fv,
                     input logic acc, input logic wide);
    logic [15:0] step;
    exp_t e;
    @(negedge clk);
    {lpbk_switch, cfg_load, power_save, sw_reset} = busy;
    cnt_lo_wr = lo; cnt_hi_wr = hi; cnt_wdata = d;
    rd_cmd = rc; fifo_valid = fv; dp_access = acc; wide_mode = wide;
    @(posedge clk);
    #1;
    step  = wide ? 16'd2 : 16'd1;
    m_dev = (busy == 4'b0);
    if (rc) m_rd = 1'b0;
    else if (fv) m_rd = 1'b1;
    if (lo || hi) begin
      if (lo) m_cnt[7:0]  = d;
      if (hi) m_cnt[15:8] = d;
      m_done = 1'b0;
    end else if (acc) begin
      m_cnt  = (m_cnt >= step) ? m_cnt - step : 16'd0;
      m_done = (m_cnt == 16'd0);
    end
    e.st  = {1'b0, m_done, m_rd, m_dev, 4'b0000};
    e.cnt = m_cnt;
    e.req = req;
    sb.push_back(e);
  endtask

  // monitor
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      check(e.req, e.st, e.cnt);
    end
  end

  initial begin
    #2_000_000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #23;
    check("R8 reset", 8'h00, 16'h0000);
    rst_n = 1'b1;
    // R1: each busy source, then idle
    cyc("R1 idle",        4'b0000, 0,0,8'h00, 0,0,0,0);
    cyc("R1 sw reset",    4'b0001, 0,0,8'h00, 0,0,0,0);
    cyc("R1 power save",  4'b0010, 0,0,8'h00, 0,0,0,0);
    cyc("R1 cfg load",    4'b0100, 0,0,8'h00, 0,0,0,0);
    cyc("R1 loopback",    4'b1000, 0,0,8'h00, 0,0,0,0);
    cyc("R1 recover",     4'b0000, 0,0,8'h00, 0,0,0,0);
    // R2/R3: read command and data arrival
    cyc("R3 valid sets",  4'b0000, 0,0,8'h00, 0,1,0,0);
    cyc("R2 cmd clears",  4'b0000, 0,0,8'h00, 1,0,0,0);
    cyc("R2 still low",   4'b0000, 0,0,8'h00, 0,0,0,0);
    cyc("R3 valid",       4'b0000, 0,0,8'h00, 0,1,0,0);
    cyc("R2 cmd wins",    4'b0000, 0,0,8'h00, 1,1,0,0);
    cyc("R3 valid again", 4'b0000, 0,0,8'h00, 0,1,0,0);
    // R4: byte-lane loads
    cyc("R4 lo load",     4'b0000, 1,0,8'h05, 0,0,0,0);
    cyc("R4 hi load",     4'b0000, 0,1,8'hA3, 0,0,0,0);
    cyc("R4 both load",   4'b0000, 1,1,8'h00, 0,0,0,0);
    cyc("R4 lo only",     4'b0000, 1,0,8'h05, 0,0,0,0);
    // R6/R7/R3: narrow countdown, back-to-back reads keep bit 5 high
    for (int i = 0; i < 5; i++)
      cyc("R6 R7 R3 narrow step", 4'b0000, 0,0,8'h00, 0,0,1,0);
    cyc("R9 idle hold",   4'b0000, 0,0,8'h00, 0,0,0,0);
    cyc("R6 saturate",    4'b0000, 0,0,8'h00, 0,0,1,0);
    // R6 wide mode with odd count
    cyc("R4 load 3",      4'b0000, 1,0,8'h03, 0,0,0,1);
    cyc("R6 wide step",   4'b0000, 0,0,8'h00, 0,0,1,1);
    cyc("R6 wide sat",    4'b0000, 0,0,8'h00, 0,0,1,1);
    // R7 zero load
    cyc("R7 zero load",   4'b0000, 1,1,8'h00, 0,0,0,0);
    cyc("R7 zero hold",   4'b0000, 0,0,8'h00, 0,0,0,0);
    cyc("R7 zero access", 4'b0000, 0,0,8'h00, 0,0,1,0);
    // R5 write versus access in the same cycle
    cyc("R5 write wins",  4'b0000, 0,1,8'h01, 0,0,1,1);
    cyc("R9 hold",        4'b0000, 0,0,8'h00, 0,0,0,0);
    cyc("R6 wide big",    4'b0000, 0,0,8'h00, 0,0,1,1);
    cyc("R5 lo write wins", 4'b0000, 1,0,8'h02, 0,0,1,0);
    cyc("R6 wide to zero", 4'b0000, 0,1,8'h00, 0,0,0,1);
    cyc("R7 wide done",   4'b0000, 0,0,8'h00, 0,0,1,1);
    cyc("R1 busy mid",    4'b0110, 0,0,8'h00, 0,0,0,0);
    cyc("R9 final",       4'b0000, 0,0,8'h00, 0,0,0,0);
    @(negedge clk);
    @(negedge clk);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule